// File: doc/BRIEF.md
# Scalar Operand Interlock Scoreboard

This block decides, one instruction at a time, whether an in-order scalar pipeline may issue the instruction now or must insert a bubble. It keeps one countdown per architectural register. An accepted writer loads that countdown from the stage number at which its result appears. Stage numbers run address=1, branch=3, execute=4, memory=5, writeback=6. Every consumer operand carries its own read stage, so the bubble count depends on both sides of the dependency: it equals the producer's result stage minus the consumer's read stage, reduced by any independent cycles that separate the two, and never below zero.

Instructions enter on a valid/ready handshake. An instruction is taken on a rising edge where `in_valid` and `in_ready` are both high. While `in_ready` is low, the source keeps the instruction and all its operand fields stable. `in_ready` depends only on the presented operand fields and `flush`, never on `in_valid`. The block also holds back a new write to a register whose older write is still pending, until the new result would land strictly after the old one. A `flush` clears every pending entry and takes no instruction in that cycle.

Top module: `scalar_interlock`

## Requirements
- R1: A producer with result stage 4, followed in the very next cycle by a consumer reading that register at stage 4, causes zero bubbles.
- R2: A producer with result stage 5 followed directly by a stage-4 reader of its register causes exactly one bubble.
- R3: A producer with result stage 6 followed directly by a stage-4 reader causes exactly two bubbles, with `raw_hold` high and `waw_hold` low while stalled.
- R4: A source read at stage 1 (address base) waits P-1 bubbles behind a direct producer of result stage P, so a stage-1 producer (move-immediate) causes none.
- R5: A source read at stage 3 (branch condition) waits max(0, P-3) bubbles behind a direct producer.
- R6: A source read at stage 5 (store data) stalls only behind a result stage of 6, and then for one bubble.
- R7: For any result stage P and read stage C in 1..6 with g idle cycles between the producer and the consumer, the consumer waits max(0, P-C-g) bubbles. Stage fields must hold 1..6 whenever their enable is set.
- R8: A write to a register with an older pending write of result stage Po, issued with new result stage Pn after g idle cycles, waits max(0, Po-Pn-g) bubbles, with `waw_hold` high while it waits.
- R9: `in_ready` is low while `flush` is high. An instruction presented during flush is not recorded. From the cycle after a flush, or after reset, no register is pending.
- R10: A source slot k uses register field `src_idx[4k+3:4k]`, read stage `src_stg[3k+2:3k]` and enable `src_en[k]`. A slot with its enable clear, or a source naming a register that no pending writer targets, never causes a stall. An accepted instruction with `dst_en` low records nothing.
- R11: With no instruction accepted, any stall clears after at most 5 consecutive cycles.
- R12: Nothing is recorded in a cycle where `in_valid` is low, whatever the destination fields hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Clears all pending entries; blocks acceptance this cycle |
| in_valid | input | 1 | Instruction presented |
| in_ready | output | 1 | Instruction may be taken this cycle |
| src_en | input | 3 | Per-slot source enable |
| src_idx | input | 12 | Per-slot source register, 4 bits per slot |
| src_stg | input | 9 | Per-slot read stage, 3 bits per slot |
| dst_en | input | 1 | Instruction writes a register |
| dst_idx | input | 4 | Destination register |
| dst_stg | input | 3 | Stage at which the result appears |
| raw_hold | output | 1 | A presented source is not yet available |
| waw_hold | output | 1 | Destination write would overtake an older pending write |

## Verification
The read-after-write path is swept over every pairing of result stage and read stage from 1 to 6. Each pairing is tried with zero to six idle cycles in between, and the tested source sits in each of the three slots in turn. That sweep separates a wrong stage subtraction from an off-by-one in the countdown, and a wrong slot decode from a wrong comparison. The write-after-write sweep covers the same stage and gap grid with source-free writers, so it isolates the ordering check from the operand check. Disabled slots always name the very register under test with the strictest read stage, so any leak through a disabled slot shows up as extra bubbles. Separate cases cover flush during an issue, flush after a slow producer, a dropped destination, and an invalid cycle carrying a destination.

// File: rtl/sbi_pkg.sv
package sbi_pkg;
  localparam int unsigned NREG_DEF  = 16;
  localparam int unsigned NSRC_DEF  = 3;
  localparam int unsigned STGW_DEF  = 3;
  localparam int unsigned STG_LAST  = 6;   // deepest result stage (writeback)
  localparam int unsigned HOLD_MAX  = STG_LAST - 1;
endpackage

// File: rtl/sbi_entry.sv
// One scoreboard slot: counts down the cycles until a register's result sits at
// the stage where a consumer of read stage N can pick it up (value < N).
module sbi_entry #(
  parameter int unsigned CNTW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            load,
  input  logic [CNTW-1:0] load_val,
  output logic [CNTW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (clr)         cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/sbi_cmp.sv
// Selects one register's countdown and compares it with a stage number.
// Used both for operand reads (stage = read stage) and for write ordering
// (stage = new result stage): both hazards are "countdown >= stage".
module sbi_cmp #(
  parameter int unsigned NREG = 16,
  parameter int unsigned REGW = 4,
  parameter int unsigned CNTW = 3
) (
  input  logic                 en,
  input  logic [REGW-1:0]      idx,
  input  logic [CNTW-1:0]      stg,
  input  logic [NREG*CNTW-1:0] cnt_all,
  output logic                 hit
);
  logic [CNTW-1:0] sel;
  always_comb begin
    sel = cnt_all[idx*CNTW +: CNTW];
    hit = en && (sel >= stg);
  end
endmodule

// File: rtl/scalar_interlock.sv
module scalar_interlock
  import sbi_pkg::*;
#(
  parameter int unsigned NREG = NREG_DEF,
  parameter int unsigned NSRC = NSRC_DEF,
  parameter int unsigned STGW = STGW_DEF,
  localparam int unsigned REGW = $clog2(NREG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [NSRC-1:0]      src_en,
  input  logic [NSRC*REGW-1:0] src_idx,
  input  logic [NSRC*STGW-1:0] src_stg,
  input  logic                 dst_en,
  input  logic [REGW-1:0]      dst_idx,
  input  logic [STGW-1:0]      dst_stg,
  output logic                 raw_hold,
  output logic                 waw_hold
);
  localparam int unsigned CNTW = STGW;

  logic [NREG*CNTW-1:0] cnt_all;
  logic [NSRC-1:0]      src_hit;
  logic                 waw_hit;
  logic                 accept;
  logic [CNTW-1:0]      load_val;

  // Result at stage P: one cycle after acceptance the entry shows P-1.
  assign load_val = CNTW'(dst_stg - 1'b1);
  assign accept   = in_valid && in_ready;

  for (genvar r = 0; r < NREG; r++) begin : g_ent
    sbi_entry #(.CNTW(CNTW)) u_ent (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (flush),
      .load     (accept && dst_en && (dst_idx == REGW'(r))),
      .load_val (load_val),
      .cnt      (cnt_all[r*CNTW +: CNTW])
    );
  end

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    sbi_cmp #(.NREG(NREG), .REGW(REGW), .CNTW(CNTW)) u_raw (
      .en      (src_en[k]),
      .idx     (src_idx[k*REGW +: REGW]),
      .stg     (src_stg[k*STGW +: STGW]),
      .cnt_all (cnt_all),
      .hit     (src_hit[k])
    );
  end

  sbi_cmp #(.NREG(NREG), .REGW(REGW), .CNTW(CNTW)) u_waw (
    .en      (dst_en),
    .idx     (dst_idx),
    .stg     (dst_stg),
    .cnt_all (cnt_all),
    .hit     (waw_hit)
  );

  assign raw_hold = |src_hit;
  assign waw_hold = waw_hit;
  assign in_ready = !flush && !raw_hold && !waw_hold;
endmodule

// File: rtl/scalar_interlock_chk.sv
module scalar_interlock_chk
  import sbi_pkg::*;
#(
  parameter int unsigned NREG = NREG_DEF,
  parameter int unsigned NSRC = NSRC_DEF,
  parameter int unsigned STGW = STGW_DEF,
  localparam int unsigned REGW = $clog2(NREG)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 flush,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [NSRC-1:0]      src_en,
  input logic [NSRC*REGW-1:0] src_idx,
  input logic [NSRC*STGW-1:0] src_stg,
  input logic                 dst_en,
  input logic [REGW-1:0]      dst_idx,
  input logic [STGW-1:0]      dst_stg,
  input logic                 raw_hold,
  input logic                 waw_hold
);
  logic       seen;
  logic [3:0] hold_run;
  logic       lone_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  hold_run <= '0;
    else if (in_ready || flush)  hold_run <= '0;
    else if (hold_run != 4'hf)   hold_run <= hold_run + 1'b1;
  end

  assign lone_src = in_valid && (src_en == NSRC'(1)) && !dst_en;

  // R7: legal result stages only
  p_stage_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dst_en) |-> (dst_stg >= 1 && dst_stg <= STGW'(STG_LAST)));

  // R9: nothing pending right after a flush
  p_clear_after_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(flush)) |-> (!raw_hold && !waw_hold));

  // R11: stalls drain within the deepest result distance
  p_hold_bounded_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hold_run <= 4'(HOLD_MAX));

  // R1: execute result feeds an execute read with no bubble
  p_alu_chain_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(in_valid && in_ready && dst_en && dst_stg == 3'(4)) && lone_src &&
     src_idx[REGW-1:0] == $past(dst_idx) && src_stg[STGW-1:0] == 3'(4)) |-> in_ready);

  // R2: memory result stalls a direct execute read
  p_load_bubble_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(in_valid && in_ready && dst_en && dst_stg == 3'(5)) && lone_src &&
     src_idx[REGW-1:0] == $past(dst_idx) && src_stg[STGW-1:0] == 3'(4)) |-> raw_hold);

  // R3: writeback result stalls a direct execute read
  p_mul_bubble_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(in_valid && in_ready && dst_en && dst_stg == 3'(6)) && lone_src &&
     src_idx[REGW-1:0] == $past(dst_idx) && src_stg[STGW-1:0] == 3'(4)) |-> raw_hold);
endmodule

bind scalar_interlock scalar_interlock_chk #(.NREG(NREG), .NSRC(NSRC), .STGW(STGW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_ready(in_ready),
  .src_en(src_en), .src_idx(src_idx), .src_stg(src_stg), .dst_en(dst_en),
  .dst_idx(dst_idx), .dst_stg(dst_stg), .raw_hold(raw_hold), .waw_hold(waw_hold)
);

// File: tb/tb_scalar_interlock.sv
`timescale 1ns/1ps
module tb_scalar_interlock;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  src_en = '0;
  logic [11:0] src_idx = '0;
  logic [8:0]  src_stg = '0;
  logic        dst_en = 1'b0;
  logic [3:0]  dst_idx = '0;
  logic [2:0]  dst_stg = '0;
  logic        raw_hold, waw_hold;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  scalar_interlock dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_ready(in_ready),
    .src_en(src_en), .src_idx(src_idx), .src_stg(src_stg), .dst_en(dst_en),
    .dst_idx(dst_idx), .dst_stg(dst_stg), .raw_hold(raw_hold), .waw_hold(waw_hold)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic idle();
    in_valid = 1'b0; src_en = '0; dst_en = 1'b0; flush = 1'b0;
  endtask

  // All tasks start and end just after a falling edge.
  task automatic do_flush();
    idle(); flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic issue(input int r, input int p, input bit den, input bit vld);
    idle();
    in_valid = vld; dst_en = den; dst_idx = 4'(r); dst_stg = 3'(p);
    @(negedge clk);
    idle();
  endtask

  task automatic gap(input int g);
    idle();
    repeat (g) @(negedge clk);
  endtask

  // Consumer: slot k reads register r at stage c; disabled slots name r at stage 1.
  task automatic set_reader(input int r, input int c, input int k);
    in_valid = 1'b1; dst_en = 1'b0;
    src_en = 3'(1 << k);
    for (int j = 0; j < 3; j++) begin
      src_idx[j*4 +: 4] = 4'(r);
      src_stg[j*3 +: 3] = (j == k) ? 3'(c) : 3'd1;
    end
  endtask

  task automatic set_writer(input int r, input int p);
    in_valid = 1'b1; src_en = '0; dst_en = 1'b1; dst_idx = 4'(r); dst_stg = 3'(p);
  endtask

  task automatic measure(output int bub);
    bub = 0;
    for (int t = 0; t < 20; t++) begin
      #1;
      if (in_ready) break;
      bub++;
      @(negedge clk);
    end
    @(negedge clk);
    idle();
  endtask

  function automatic string tag_of(input int p, input int c);
    if (c == 4 && p == 4) return "R1";
    if (c == 4 && p == 5) return "R2";
    if (c == 4 && p == 6) return "R3";
    if (c == 1) return "R4";
    if (c == 3) return "R5";
    if (c == 5) return "R6";
    return "R7";
  endfunction

  function automatic int pos(input int v);
    return (v > 0) ? v : 0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog got=%0d exp=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int b;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: reset leaves nothing pending
    for (int r = 0; r < 16; r++) begin
      set_reader(r, 1, 0);
      #1 check("R9 reset", int'(in_ready), 1);
      @(negedge clk);
    end
    idle();

    // R1..R7: read-after-write sweep over stages, gaps and slots
    for (int k = 0; k < 3; k++)
      for (int p = 1; p <= 6; p++)
        for (int c = 1; c <= 6; c++)
          for (int g = 0; g <= 6; g++) begin
            do_flush();
            issue(5, p, 1'b1, 1'b1);
            gap(g);
            set_reader(5, c, k);
            measure(b);
            check(tag_of(p, c), b, pos(p - c - g));
          end

    // R8: write-after-write sweep
    for (int po = 1; po <= 6; po++)
      for (int pn = 1; pn <= 6; pn++)
        for (int g = 0; g <= 6; g++) begin
          do_flush();
          issue(9, po, 1'b1, 1'b1);
          gap(g);
          set_writer(9, pn);
          measure(b);
          check("R8", b, pos(po - pn - g));
        end

    // R8: hold reason for an ordering stall
    do_flush(); issue(3, 6, 1'b1, 1'b1); set_writer(3, 4);
    #1 check("R8 waw_hold", int'(waw_hold), 1);
    check("R8 raw_hold", int'(raw_hold), 0);
    measure(b);

    // R3: hold reason for an operand stall
    do_flush(); issue(3, 6, 1'b1, 1'b1); set_reader(3, 4, 1);
    #1 check("R3 raw_hold", int'(raw_hold), 1);
    check("R3 waw_hold", int'(waw_hold), 0);
    measure(b);

    // R11: deepest case drains within five cycles
    do_flush(); issue(7, 6, 1'b1, 1'b1); set_reader(7, 1, 2);
    measure(b);
    check("R11", int'(b <= 5), 1);

    // R10: other register not affected
    do_flush(); issue(5, 6, 1'b1, 1'b1); set_reader(6, 1, 0);
    measure(b);
    check("R10 other reg", b, 0);

    // R10: dst_en low records nothing
    do_flush(); issue(5, 6, 1'b0, 1'b1); set_reader(5, 1, 0);
    measure(b);
    check("R10 no dst", b, 0);

    // R12: invalid cycle records nothing
    do_flush(); issue(5, 6, 1'b1, 1'b0); set_reader(5, 1, 0);
    measure(b);
    check("R12", b, 0);

    // R9: flush blocks a same-cycle issue and it is not recorded
    do_flush();
    set_writer(5, 6); flush = 1'b1;
    #1 check("R9 ready in flush", int'(in_ready), 0);
    @(negedge clk);
    idle();
    set_reader(5, 1, 0);
    measure(b);
    check("R9 dropped", b, 0);

    // R9: flush clears a pending slow result
    do_flush(); issue(5, 6, 1'b1, 1'b1); do_flush(); set_reader(5, 1, 0);
    measure(b);
    check("R9 cleared", b, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule